// File: doc/BRIEF.md
# Partial-Subblock Translation Buffer

A fully associative address translation buffer in which each entry maps an aligned block of sixteen consecutive 4KB virtual pages. Every entry stores one virtual region tag, one physical base frame, one attribute field and a sixteen-bit vector of per-page valid bits. The physical block is aligned the same way as the virtual block, so a base page's physical page number is the stored base followed by the page's position in the block. Because the frame and the attributes are shared, a new 4KB mapping joins an entry only when it continues the entry's physical run at the right position and carries identical attributes.

Lookups are combinational. A hit returns the physical address and the attributes, and a miss returns zeros. Updates take effect at the next clock edge. Only one update is performed per cycle, and the priority is flush, then single-page invalidate, then fill. A fill either merges into the entry for its region, overwrites that entry when the merge is not allowed, or claims a new entry. A new entry comes from the lowest-numbered empty slot if there is one, and otherwise from a round-robin victim pointer.

Top module: `psb_xlate`

## Requirements
- R1: After reset is released, every lookup misses.
- R2: A lookup hit returns the physical address {stored base, va[15:12], va[11:0]} and the entry's stored attributes.
- R3: A lookup miss drives lk_hit low and both lk_pa and lk_attr to zero.
- R4: A fill whose region already has an entry merges when fill_ppn[PPN_W-1:4] equals the stored base and fill_attr equals the stored attributes. Its page becomes valid, and the other valid pages of the entry are kept.
- R5: A fill whose region has an entry but fails the merge test overwrites that entry's base and attributes and leaves only the new page valid. A region never occupies two entries.
- R6: A fill with fill_ppn[3:0] different from fill_va[15:12] is ignored, and the buffer contents are unchanged.
- R7: A fill for a region with no entry takes the lowest-numbered empty entry. When no entry is empty, it takes the entry at the round-robin pointer and advances the pointer by one, wrapping after the last entry. Reset and flush return the pointer to entry 0.
- R8: Invalidating a page clears only that page's valid bit in its region's entry. Other pages of the entry still hit.
- R9: Flush empties every entry in one cycle. Flush takes priority over invalidate, and invalidate takes priority over fill in the same cycle; the losing requests are dropped.
- R10: An entry whose valid bits are all clear counts as empty and is reused before any round-robin victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_va | input | VA_W | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | PA_W | Translated physical address, zero on miss |
| lk_attr | output | ATTR_W | Page attributes, zero on miss |
| fill_en | input | 1 | Install one 4KB mapping |
| fill_va | input | VA_W | Virtual address of the mapping |
| fill_ppn | input | PA_W-12 | Physical page number of the mapping |
| fill_attr | input | ATTR_W | Attributes of the mapping |
| inv_en | input | 1 | Invalidate one 4KB page |
| inv_va | input | VA_W | Virtual address of the page to invalidate |
| flush | input | 1 | Empty the whole buffer |

## Verification
The merge path is driven by filling all sixteen pages of one region with a consecutive physical run. After each fill, all sixteen positions are looked up, which tells a correct merge apart from a fill that loses or invents neighbouring pages. Fills that break the run by a different base or different attributes are then applied, and the bench checks that the entry is overwritten, not merged. A misaligned fill is checked to leave the entry untouched. Sequences of distinct regions beyond the entry count show whether free-slot selection and the round-robin victim order are kept apart. Simultaneous flush, invalidate and fill requests check the priority order.

// File: rtl/psb_pkg.sv
package psb_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_FILL  = 2'd1,
    OP_INV   = 2'd2,
    OP_FLUSH = 2'd3
  } psb_op_e;
endpackage

// File: rtl/psb_match.sv
module psb_match #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 16,
  parameter int IDX_W   = 3
) (
  input  logic [TAG_W-1:0]   tags [ENTRIES],
  input  logic [ENTRIES-1:0] live,
  input  logic [TAG_W-1:0]   key,
  output logic [ENTRIES-1:0] hit_vec,
  output logic [IDX_W-1:0]   hit_idx,
  output logic               any
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = live[g] && (tags[g] == key);
  end

  // at most one bit set, so OR-ing indices yields the matching one
  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) hit_idx = hit_idx | IDX_W'(i);
    end
  end

  assign any = |hit_vec;
endmodule

// File: rtl/psb_victim.sv
module psb_victim #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic [ENTRIES-1:0] live,
  input  logic               take,
  output logic [IDX_W-1:0]   victim,
  output logic               has_free
);
  logic [IDX_W-1:0] rr_q, rr_d, free_idx;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!live[i]) free_idx = IDX_W'(i);
    end
  end

  assign has_free = ~&live;
  assign victim   = has_free ? free_idx : rr_q;

  always_comb begin
    rr_d = rr_q;
    if (flush) begin
      rr_d = '0;
    end else if (take && !has_free) begin
      rr_d = (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= rr_d;
  end
endmodule

// File: rtl/psb_xlate.sv
module psb_xlate #(
  parameter int VA_W     = 32,
  parameter int PA_W     = 32,
  parameter int ATTR_W   = 4,
  parameter int ENTRIES  = 8,
  parameter int PAGE_LOG = 12,
  parameter int SUB_LOG  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [VA_W-1:0]            lk_va,
  output logic                       lk_hit,
  output logic [PA_W-1:0]            lk_pa,
  output logic [ATTR_W-1:0]          lk_attr,
  input  logic                       fill_en,
  input  logic [VA_W-1:0]            fill_va,
  input  logic [PA_W-PAGE_LOG-1:0]   fill_ppn,
  input  logic [ATTR_W-1:0]          fill_attr,
  input  logic                       inv_en,
  input  logic [VA_W-1:0]            inv_va,
  input  logic                       flush
);
  import psb_pkg::*;

  localparam int SUB_N  = 1 << SUB_LOG;
  localparam int VTAG_W = VA_W - PAGE_LOG - SUB_LOG;
  localparam int PPN_W  = PA_W - PAGE_LOG;
  localparam int BASE_W = PPN_W - SUB_LOG;
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [VTAG_W-1:0] tag_q  [ENTRIES];
  logic [BASE_W-1:0] base_q [ENTRIES];
  logic [ATTR_W-1:0] attr_q [ENTRIES];
  logic [SUB_N-1:0]  vld_q  [ENTRIES];
  logic [SUB_N-1:0]  vld_d  [ENTRIES];
  logic [ENTRIES-1:0] live, we;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_live
    assign live[g] = |vld_q[g];
  end

  // ---------------- update side ----------------
  psb_op_e op;
  always_comb begin
    if (flush)        op = OP_FLUSH;
    else if (inv_en)  op = OP_INV;
    else if (fill_en) op = OP_FILL;
    else              op = OP_IDLE;
  end

  logic [VA_W-1:0]    upd_va;
  logic [VTAG_W-1:0]  upd_tag;
  logic [SUB_LOG-1:0] upd_sub;
  logic [BASE_W-1:0]  fill_base;
  logic [ENTRIES-1:0] upd_hit_vec;
  logic [IDX_W-1:0]   upd_idx, victim;
  logic               upd_any, has_free, aligned, compat, take;

  assign upd_va    = (op == OP_INV) ? inv_va : fill_va;
  assign upd_tag   = upd_va[VA_W-1 -: VTAG_W];
  assign upd_sub   = upd_va[PAGE_LOG +: SUB_LOG];
  assign fill_base = fill_ppn[PPN_W-1 -: BASE_W];
  assign aligned   = (fill_ppn[SUB_LOG-1:0] == upd_sub);

  psb_match #(.ENTRIES(ENTRIES), .TAG_W(VTAG_W), .IDX_W(IDX_W)) u_upd_match (
    .tags(tag_q), .live(live), .key(upd_tag),
    .hit_vec(upd_hit_vec), .hit_idx(upd_idx), .any(upd_any)
  );

  assign compat = (base_q[upd_idx] == fill_base) && (attr_q[upd_idx] == fill_attr);
  assign take   = (op == OP_FILL) && aligned && !upd_any;

  psb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .flush(op == OP_FLUSH), .live(live),
    .take(take), .victim(victim), .has_free(has_free)
  );

  always_comb begin
    we = '0;
    for (int i = 0; i < ENTRIES; i++) vld_d[i] = vld_q[i];
    unique case (op)
      OP_FLUSH: for (int i = 0; i < ENTRIES; i++) vld_d[i] = '0;
      OP_INV: if (upd_any) vld_d[upd_idx][upd_sub] = 1'b0;
      OP_FILL: if (aligned) begin
        if (upd_any && compat) begin
          vld_d[upd_idx][upd_sub] = 1'b1;
        end else if (upd_any) begin
          we[upd_idx]    = 1'b1;
          vld_d[upd_idx] = SUB_N'(1) << upd_sub;
        end else begin
          we[victim]     = 1'b1;
          vld_d[victim]  = SUB_N'(1) << upd_sub;
        end
      end
      default: ;
    endcase
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q[g] <= '0;
      else        vld_q[g] <= vld_d[g];
    end
    always_ff @(posedge clk) begin
      if (we[g]) begin
        tag_q[g]  <= upd_tag;
        base_q[g] <= fill_base;
        attr_q[g] <= fill_attr;
      end
    end
  end

  // ---------------- lookup side ----------------
  logic [ENTRIES-1:0] lk_hit_vec;
  logic [IDX_W-1:0]   lk_idx;
  logic               lk_any;
  logic [SUB_LOG-1:0] lk_sub;

  assign lk_sub = lk_va[PAGE_LOG +: SUB_LOG];

  psb_match #(.ENTRIES(ENTRIES), .TAG_W(VTAG_W), .IDX_W(IDX_W)) u_lk_match (
    .tags(tag_q), .live(live), .key(lk_va[VA_W-1 -: VTAG_W]),
    .hit_vec(lk_hit_vec), .hit_idx(lk_idx), .any(lk_any)
  );

  assign lk_hit  = lk_any && vld_q[lk_idx][lk_sub];
  assign lk_pa   = lk_hit ? {base_q[lk_idx], lk_sub, lk_va[PAGE_LOG-1:0]} : '0;
  assign lk_attr = lk_hit ? attr_q[lk_idx] : '0;
endmodule

// File: rtl/psb_xlate_chk.sv
module psb_xlate_chk #(
  parameter int VA_W     = 32,
  parameter int PA_W     = 32,
  parameter int ATTR_W   = 4,
  parameter int ENTRIES  = 8,
  parameter int PAGE_LOG = 12,
  parameter int SUB_LOG  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               flush,
  input logic               inv_en,
  input logic [VA_W-1:0]    inv_va,
  input logic [VA_W-1:0]    lk_va,
  input logic               lk_hit,
  input logic [PA_W-1:0]    lk_pa,
  input logic [ATTR_W-1:0]  lk_attr,
  input logic [ENTRIES-1:0] upd_hit_vec,
  input logic [ENTRIES-1:0] lk_hit_vec
);
  localparam int LOW_W = PAGE_LOG + SUB_LOG;

  p_offset_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_pa[LOW_W-1:0] == lk_va[LOW_W-1:0]);

  p_miss_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_pa == '0 && lk_attr == '0));

  p_one_region_upd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd_hit_vec));

  p_one_region_lk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit_vec));

  p_inv_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && !flush) |=>
      !(lk_hit && lk_va[VA_W-1:PAGE_LOG] == $past(inv_va[VA_W-1:PAGE_LOG])));

  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit);
endmodule

bind psb_xlate psb_xlate_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .ATTR_W(ATTR_W), .ENTRIES(ENTRIES),
  .PAGE_LOG(PAGE_LOG), .SUB_LOG(SUB_LOG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .inv_en(inv_en), .inv_va(inv_va),
  .lk_va(lk_va), .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_attr(lk_attr),
  .upd_hit_vec(upd_hit_vec), .lk_hit_vec(lk_hit_vec)
);

// File: tb/sim_psb_xlate.sv
module sim_psb_xlate;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] lk_va, fill_va, inv_va;
  logic [19:0] fill_ppn;
  logic [3:0]  fill_attr, lk_attr;
  logic        fill_en, inv_en, flush, lk_hit;
  logic [31:0] lk_pa;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  psb_xlate #(.ENTRIES(4)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_va(lk_va), .lk_hit(lk_hit), .lk_pa(lk_pa),
    .lk_attr(lk_attr), .fill_en(fill_en), .fill_va(fill_va), .fill_ppn(fill_ppn),
    .fill_attr(fill_attr), .inv_en(inv_en), .inv_va(inv_va), .flush(flush)
  );

  function automatic logic [31:0] mk_va(input logic [15:0] t, input int s, input logic [11:0] o);
    return {t, 4'(s), o};
  endfunction

  task automatic look(input string rq, input logic [31:0] va, input bit eh,
                      input logic [15:0] eb, input logic [3:0] ea);
    logic [31:0] epa;
    epa = eh ? {eb, va[15:0]} : 32'h0;
    if (!eh) ea = 4'h0;
    @(negedge clk);
    lk_va = va;
    #1;
    n_run++;
    if (lk_hit !== eh || lk_pa !== epa || lk_attr !== ea) begin
      n_fail++;
      $display("FAIL %s va=%h hit=%0b/%0b pa=%h/%h attr=%h/%h", rq, va,
               lk_hit, eh, lk_pa, epa, lk_attr, ea);
    end
  endtask

  task automatic fill(input logic [31:0] va, input logic [19:0] ppn, input logic [3:0] a);
    @(negedge clk);
    fill_en = 1; fill_va = va; fill_ppn = ppn; fill_attr = a;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic inval(input logic [31:0] va);
    @(negedge clk);
    inv_en = 1; inv_va = va;
    @(negedge clk);
    inv_en = 0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1;
    @(negedge clk);
    flush = 0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    rst_n = 0; lk_va = 0; fill_va = 0; inv_va = 0; fill_ppn = 0; fill_attr = 0;
    fill_en = 0; inv_en = 0; flush = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: empty after reset
    for (int t = 0; t < 4; t++)
      for (int s = 0; s < 16; s++) look("R1", mk_va(16'(t), s, 12'h0), 0, 0, 0);

    // R4/R2: grow one region page by page with a consecutive physical run
    for (int s = 0; s < 16; s++) begin
      fill(mk_va(16'h0010, s, 12'h0), {16'h0A00, 4'(s)}, 4'h5);
      for (int q = 0; q < 16; q++)
        look("R4", mk_va(16'h0010, q, 12'(12'h123 ^ q)), q <= s, 16'h0A00, 4'h5);
    end

    // R5: different base overwrites, only new page left
    fill(mk_va(16'h0010, 3, 0), {16'h0B00, 4'd3}, 4'h5);
    look("R5", mk_va(16'h0010, 3, 12'hABC), 1, 16'h0B00, 4'h5);
    look("R5", mk_va(16'h0010, 4, 12'hABC), 0, 0, 0);
    look("R5", mk_va(16'h0010, 0, 12'hABC), 0, 0, 0);
    // R5: same base, different attributes overwrites too
    fill(mk_va(16'h0010, 5, 0), {16'h0B00, 4'd5}, 4'h6);
    look("R5", mk_va(16'h0010, 5, 12'h001), 1, 16'h0B00, 4'h6);
    look("R5", mk_va(16'h0010, 3, 12'h001), 0, 0, 0);

    // R6: misaligned fills change nothing
    fill(mk_va(16'h0010, 6, 0), {16'h0B00, 4'd7}, 4'h6);
    look("R6", mk_va(16'h0010, 6, 0), 0, 0, 0);
    look("R6", mk_va(16'h0010, 7, 0), 0, 0, 0);
    look("R6", mk_va(16'h0010, 5, 0), 1, 16'h0B00, 4'h6);
    fill(mk_va(16'h0020, 2, 0), {16'h0C00, 4'd9}, 4'h1);
    look("R6", mk_va(16'h0020, 2, 0), 0, 0, 0);

    // R9: flush empties; simultaneous fill is dropped
    @(negedge clk);
    flush = 1; fill_en = 1; fill_va = mk_va(16'h0030, 0, 0); fill_ppn = {16'h0D00, 4'd0}; fill_attr = 2;
    @(negedge clk);
    flush = 0; fill_en = 0;
    look("R9", mk_va(16'h0010, 5, 0), 0, 0, 0);
    look("R9", mk_va(16'h0030, 0, 0), 0, 0, 0);

    // R7: free slots first, then round robin from entry 0
    for (int t = 0; t < 4; t++) fill(mk_va(16'(16'h00A0 + t), 0, 0), {16'(16'h0E00 + t), 4'd0}, 4'h3);
    for (int t = 0; t < 4; t++) look("R7", mk_va(16'(16'h00A0 + t), 0, 12'h7), 1, 16'(16'h0E00 + t), 4'h3);
    fill(mk_va(16'h00A4, 0, 0), {16'h0E04, 4'd0}, 4'h3);
    look("R7", mk_va(16'h00A0, 0, 0), 0, 0, 0);
    look("R7", mk_va(16'h00A1, 0, 0), 1, 16'h0E01, 4'h3);
    fill(mk_va(16'h00A5, 0, 0), {16'h0E05, 4'd0}, 4'h3);
    look("R7", mk_va(16'h00A1, 0, 0), 0, 0, 0);
    look("R7", mk_va(16'h00A2, 0, 0), 1, 16'h0E02, 4'h3);
    look("R7", mk_va(16'h00A4, 0, 0), 1, 16'h0E04, 4'h3);

    // R10: emptied entry (A3 in slot 3) is reused; pointer victim A2 survives
    inval(mk_va(16'h00A3, 0, 0));
    look("R10", mk_va(16'h00A3, 0, 0), 0, 0, 0);
    fill(mk_va(16'h00A6, 0, 0), {16'h0E06, 4'd0}, 4'h3);
    look("R10", mk_va(16'h00A2, 0, 0), 1, 16'h0E02, 4'h3);
    look("R10", mk_va(16'h00A6, 0, 0), 1, 16'h0E06, 4'h3);
    look("R10", mk_va(16'h00A5, 0, 0), 1, 16'h0E05, 4'h3);

    // R8: invalidate one page of a two-page entry
    fill(mk_va(16'h00A6, 1, 0), {16'h0E06, 4'd1}, 4'h3);
    inval(mk_va(16'h00A6, 0, 0));
    look("R8", mk_va(16'h00A6, 0, 0), 0, 0, 0);
    look("R8", mk_va(16'h00A6, 1, 12'h44), 1, 16'h0E06, 4'h3);

    // R9: invalidate wins over fill in the same cycle
    @(negedge clk);
    inv_en = 1; inv_va = mk_va(16'h00A6, 1, 0);
    fill_en = 1; fill_va = mk_va(16'h00A6, 2, 0); fill_ppn = {16'h0E06, 4'd2}; fill_attr = 3;
    @(negedge clk);
    inv_en = 0; fill_en = 0;
    look("R9", mk_va(16'h00A6, 1, 0), 0, 0, 0);
    look("R9", mk_va(16'h00A6, 2, 0), 0, 0, 0);

    // R9/R7: flush resets pointer; after 5 fills the first region is the one evicted
    do_flush();
    for (int t = 0; t < 5; t++) fill(mk_va(16'(16'h0100 + t), 0, 0), {16'(16'h0F00 + t), 4'd0}, 4'h2);
    look("R7", mk_va(16'h0100, 0, 0), 0, 0, 0);
    for (int t = 1; t < 5; t++) look("R7", mk_va(16'(16'h0100 + t), 0, 0), 1, 16'(16'h0F00 + t), 4'h2);

    finish_up();
  end
endmodule